// File: doc/BRIEF.md
# I2C Master Bus Event Sequencer

This block produces the individual bus events of an I2C master on open-drain SCL and SDA lines: Start, Repeated Start, Stop, the reception of one byte, and the acknowledge phase that follows a received byte. The host requests one event at a time by writing a one-hot command word. The matching enable flag then stays set while the event runs, and the block clears that flag itself when the event's last half-period ends. Sending a byte is out of scope here. Only the shared receive shift path is built.

The SCL half-period is set in system clocks by a divider input. Each line is modelled by a pull-low output and a sampled input. The high half of every SCL pulse is counted only while the sampled SCL is actually high, so a device holding the clock low simply stretches that half. A received byte is shifted in most significant bit first. It appears on a data output together with a one-cycle valid pulse. During the acknowledge phase, the host's separately held acknowledge data bit decides whether SDA is pulled low (ACK) or left released (NACK).

Top module: `i2c_seq_engine`

## Requirements
- R1: Command bit 0 (Start), from an idle bus, pulls SDA low at once with SCL released. After one half-period it pulls SCL low and clears enable flag 0 in the same clock, so the flag is high for exactly one half-period.
- R2: Command bit 1 (Repeated Start) releases SDA, then releases SCL, then pulls SDA low while SCL is high, then pulls SCL low. Each step lasts one half-period, and flag 1 clears as SCL goes low.
- R3: Command bit 2 (Stop) pulls SDA low, then releases SCL, then releases SDA while SCL is high. It clears flag 2 one half-period later, leaving both lines released.
- R4: Command bit 3 (Receive) releases SDA and clocks eight SCL pulses. SDA is sampled at the end of each high half, most significant bit first. Flag 3 clears at the end of the eighth bit, in the same clock as a one-cycle rx_valid pulse that carries the byte.
- R5: Command bit 4 (Acknowledge) clocks one SCL pulse during which SDA carries ack_bit. A value of 0 pulls SDA low (ACK) and a value of 1 leaves SDA released (NACK). Flag 4 clears when SCL is pulled low again.
- R6: A command written while busy is high is ignored and leaves the running event and its flag unchanged.
- R7: A command word with no bit set, or with more than one bit set, is ignored. No flag is set and busy stays low.
- R8: One half-period lasts half_div system clocks, and a half_div of 0 is treated as 1.
- R9: A half-period in which the block has released SCL is counted only while scl_in reads high, so an external low on SCL holds the event in place.
- R10: After reset, both lines are released, all flags are zero, and busy and rx_valid are low.
- R11: While a receive is in progress, SDA is never changed by the block in a cycle where SCL was released and still is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_div | input | DIV_W | SCL half-period in system clocks (0 means 1) |
| cmd_wr | input | 1 | Command write strobe |
| cmd_en | input | 5 | One-hot command: 0 Start, 1 Repeated Start, 2 Stop, 3 Receive, 4 Acknowledge |
| ack_bit | input | 1 | Acknowledge data bit: 0 ACK, 1 NACK |
| en_flags | output | 5 | Enable flags, cleared by hardware when the event completes |
| busy | output | 1 | An event is in progress |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle pulse when rx_data holds a new byte |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_low | output | 1 | Pull SCL low when 1, release when 0 |
| sda_low | output | 1 | Pull SDA low when 1, release when 0 |

## Verification
The hardest state to reach is a Stop whose SCL release is held off by another device, because the block must sit in its released-clock phase without counting. The bench keeps its own wired-AND line model. It forces the SCL line low before issuing Stop, holds it there for many half-periods while checking that the Stop flag stays set and no Stop edge appears, and then lets go. Receive bytes come from a bench-side slave that changes SDA only after SCL falls, and the ACK and NACK levels are sampled on the rising SCL edge of the acknowledge pulse.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
   localparam int EV_N      = 5;
   localparam int EV_START  = 0;
   localparam int EV_RSTART = 1;
   localparam int EV_STOP   = 2;
   localparam int EV_RECV   = 3;
   localparam int EV_ACK    = 4;

   typedef enum logic [3:0] {
      S_IDLE,
      S_ST_A,
      S_RS_A, S_RS_B, S_RS_C,
      S_SP_A, S_SP_B, S_SP_C,
      S_BIT_LO, S_BIT_HI,
      S_ACK_LO, S_ACK_HI
   } seq_state_e;
endpackage

// File: rtl/i2c_half_timer.sv
module i2c_half_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             gate,
   input  logic [DIV_W-1:0] half_div,
   output logic             expire
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] limit;

   assign limit  = (half_div == '0) ? DIV_W'(1) : half_div;
   assign expire = gate && (cnt == limit - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (clr || expire) cnt <= '0;
      else if (gate)          cnt <= cnt + DIV_W'(1);
   end
endmodule

// File: rtl/i2c_rx_shift.sv
module i2c_rx_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift,
   input  logic         bit_in,
   output logic [W-1:0] data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     data <= '0;
      else if (shift) data <= {data[W-2:0], bit_in};
   end
endmodule

// File: rtl/i2c_seq_engine.sv
module i2c_seq_engine
   import i2c_seq_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  half_div,
   input  logic              cmd_wr,
   input  logic [EV_N-1:0]   cmd_en,
   input  logic              ack_bit,
   output logic [EV_N-1:0]   en_flags,
   output logic              busy,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_low,
   output logic              sda_low
);
   localparam int CNT_W = $clog2(DATA_W);

   if (DIV_W < 2)       $error("DIV_W must be at least 2");
   if (DATA_W < 2)      $error("DATA_W must be at least 2");
   if (SYNC_STAGES < 0) $error("SYNC_STAGES must not be negative");

   logic scl_s, sda_s;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign scl_s = scl_in;
      assign sda_s = sda_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] scl_q, sda_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
         end else begin
            scl_q[0] <= scl_in;
            sda_q[0] <= sda_in;
            for (int i = 1; i < SYNC_STAGES; i++) begin
               scl_q[i] <= scl_q[i-1];
               sda_q[i] <= sda_q[i-1];
            end
         end
      end
      assign scl_s = scl_q[SYNC_STAGES-1];
      assign sda_s = sda_q[SYNC_STAGES-1];
   end

   seq_state_e       state;
   logic [CNT_W-1:0] bit_cnt;
   logic             accept, expire, gate, shift;

   assign busy   = (state != S_IDLE);
   assign accept = cmd_wr && !busy && $onehot(cmd_en);
   assign gate   = (state == S_RS_B || state == S_SP_B ||
                    state == S_BIT_HI || state == S_ACK_HI) ? scl_s : 1'b1;
   assign shift  = (state == S_BIT_HI) && expire;

   i2c_half_timer #(.DIV_W(DIV_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(accept), .gate(gate),
      .half_div(half_div), .expire(expire)
   );

   i2c_rx_shift #(.W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .shift(shift), .bit_in(sda_s), .data(rx_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         en_flags <= '0;
         scl_low  <= 1'b0;
         sda_low  <= 1'b0;
         bit_cnt  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         case (state)
            S_IDLE: if (accept) begin
               en_flags <= cmd_en;
               if (cmd_en[EV_START]) begin
                  state <= S_ST_A; sda_low <= 1'b1;
               end else if (cmd_en[EV_RSTART]) begin
                  state <= S_RS_A; sda_low <= 1'b0;
               end else if (cmd_en[EV_STOP]) begin
                  state <= S_SP_A; sda_low <= 1'b1;
               end else if (cmd_en[EV_RECV]) begin
                  state <= S_BIT_LO; sda_low <= 1'b0; bit_cnt <= '0;
               end else begin
                  state <= S_ACK_LO; sda_low <= ~ack_bit;
               end
            end
            S_ST_A: if (expire) begin
               scl_low <= 1'b1; state <= S_IDLE; en_flags <= '0;
            end
            S_RS_A: if (expire) begin
               scl_low <= 1'b0; state <= S_RS_B;
            end
            S_RS_B: if (expire) begin
               sda_low <= 1'b1; state <= S_RS_C;
            end
            S_RS_C: if (expire) begin
               scl_low <= 1'b1; state <= S_IDLE; en_flags <= '0;
            end
            S_SP_A: if (expire) begin
               scl_low <= 1'b0; state <= S_SP_B;
            end
            S_SP_B: if (expire) begin
               sda_low <= 1'b0; state <= S_SP_C;
            end
            S_SP_C: if (expire) begin
               state <= S_IDLE; en_flags <= '0;
            end
            S_BIT_LO: if (expire) begin
               scl_low <= 1'b0; state <= S_BIT_HI;
            end
            S_BIT_HI: if (expire) begin
               scl_low <= 1'b1;
               if (bit_cnt == CNT_W'(DATA_W-1)) begin
                  state <= S_IDLE; en_flags <= '0; rx_valid <= 1'b1;
               end else begin
                  bit_cnt <= bit_cnt + CNT_W'(1); state <= S_BIT_LO;
               end
            end
            S_ACK_LO: if (expire) begin
               scl_low <= 1'b0; state <= S_ACK_HI;
            end
            S_ACK_HI: if (expire) begin
               scl_low <= 1'b1; state <= S_IDLE; en_flags <= '0;
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/i2c_seq_engine_chk.sv
module i2c_seq_engine_chk
   import i2c_seq_pkg::*;
(
   input logic            clk,
   input logic            rst_n,
   input logic            cmd_wr,
   input logic            busy,
   input logic [EV_N-1:0] en_flags,
   input logic            rx_valid,
   input logic            scl_low,
   input logic            sda_low
);
   // R7: at most one event flag is ever set
   a_r7_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(en_flags));

   // R6: a write during a busy cycle sets no new flag
   a_r6_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_wr) |=> ((en_flags & ~$past(en_flags)) == '0));

   // R4: a byte is delivered only at the end of a receive
   a_r4_valid_after_recv: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> ($past(en_flags[EV_RECV]) && !en_flags[EV_RECV]));

   // R11: SDA is held while SCL stays released during a receive
   a_r11_rx_sda_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (en_flags[EV_RECV] && !scl_low && !$past(scl_low)) |-> $stable(sda_low));
endmodule

bind i2c_seq_engine i2c_seq_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .busy(busy),
   .en_flags(en_flags), .rx_valid(rx_valid), .scl_low(scl_low), .sda_low(sda_low)
);

// File: tb/i2c_seq_engine_tb.sv
module i2c_seq_engine_tb;
   localparam int DIV_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [DIV_W-1:0] half_div = 8'd4;
   logic             cmd_wr = 1'b0;
   logic [4:0]       cmd_en = '0;
   logic             ack_bit = 1'b0;
   logic [4:0]       en_flags;
   logic             busy, rx_valid, scl_low, sda_low;
   logic [7:0]       rx_data;
   logic             stretch = 1'b0;
   logic             slave_sda = 1'b1;
   wire              scl_line = ~scl_low & ~stretch;
   wire              sda_line = ~sda_low & slave_sda;

   int checks = 0;
   int errors = 0;
   int start_cnt = 0;
   int stop_cnt = 0;
   int rx_seen = 0;
   bit done = 1'b0;
   logic [7:0] exp_q[$];

   always #4 clk = ~clk;

   i2c_seq_engine #(.DIV_W(DIV_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .half_div(half_div), .cmd_wr(cmd_wr),
      .cmd_en(cmd_en), .ack_bit(ack_bit), .en_flags(en_flags), .busy(busy),
      .rx_data(rx_data), .rx_valid(rx_valid), .scl_in(scl_line),
      .sda_in(sda_line), .scl_low(scl_low), .sda_low(sda_low)
   );

   always @(negedge sda_line) if (rst_n && scl_line) start_cnt++;
   always @(posedge sda_line) if (rst_n && scl_line) stop_cnt++;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // scoreboard monitor (R4)
   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         rx_seen++;
         if (exp_q.size() == 0) check(1'b0, "R4 unexpected byte", rx_data, -1);
         else begin
            automatic logic [7:0] e = exp_q.pop_front();
            check(rx_data == e, "R4 received byte", rx_data, e);
         end
      end
   end

   task automatic issue(input logic [4:0] v);
      @(negedge clk); cmd_wr = 1'b1; cmd_en = v;
      @(negedge clk); cmd_wr = 1'b0; cmd_en = '0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic slave_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         slave_sda = b[i];
         @(posedge scl_line);
         @(negedge scl_line);
      end
      slave_sda = 1'b1;
   endtask

   task automatic do_rx(input logic [7:0] b);
      exp_q.push_back(b);
      fork
         slave_byte(b);
         issue(5'b01000);
      join
      wait_idle();
   endtask

   task automatic do_ack(input logic a, input string req);
      logic seen = 1'bx;
      ack_bit = a;
      fork
         begin @(posedge scl_line); #1 seen = sda_line; end
         issue(5'b10000);
      join
      wait_idle();
      check(seen == a, req, seen, a);
      check(en_flags == 5'd0, "R5 ack flag cleared", en_flags, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      start_cnt = 0; stop_cnt = 0;
      // R10 reset state
      check(!scl_low && !sda_low, "R10 lines released", {scl_low, sda_low}, 0);
      check(en_flags == 0 && !busy && !rx_valid, "R10 idle", {en_flags, busy}, 0);

      // R7 zero and multi-bit commands ignored
      issue(5'b00011);
      check(en_flags == 0 && !busy, "R7 multi-bit ignored", {en_flags, busy}, 0);
      issue(5'b00000);
      check(en_flags == 0 && !busy && !sda_low, "R7 empty ignored", {en_flags, busy}, 0);

      // R1 + R8 start duration
      half_div = 8'd4;
      issue(5'b00001);
      n = 0;
      while (en_flags[0]) begin @(negedge clk); n++; end
      check(n == 4, "R1 R8 start flag duration", n, 4);
      check(scl_low && sda_low, "R1 lines after start", {scl_low, sda_low}, 3);
      check(start_cnt == 1, "R1 start edge seen", start_cnt, 1);

      // R4 receive with R6 busy write ignored
      half_div = 8'd3;
      exp_q.push_back(8'hA5);
      fork
         slave_byte(8'hA5);
         begin
            issue(5'b01000);
            issue(5'b00100);
            check(en_flags == 5'b01000, "R6 busy write ignored", en_flags, 8);
         end
      join
      wait_idle();
      check(en_flags == 0 && scl_low, "R4 recv flag cleared", en_flags, 0);
      check(stop_cnt == 0, "R6 no stop from ignored write", stop_cnt, 0);

      do_ack(1'b0, "R5 ACK drives SDA low");

      half_div = 8'd5;
      do_rx(8'h3C);
      do_ack(1'b1, "R5 NACK leaves SDA released");

      // R2 repeated start
      issue(5'b00010);
      wait_idle();
      check(start_cnt == 2, "R2 repeated start edge", start_cnt, 2);
      check(scl_low && sda_low && en_flags == 0, "R2 end state", {scl_low, sda_low, en_flags}, 7'b1100000);

      half_div = 8'd2;
      do_rx(8'h81);

      // R9 stretched stop, then R3
      half_div = 8'd4;
      stretch = 1'b1;
      issue(5'b00100);
      repeat (30) @(negedge clk);
      check(en_flags[2] && sda_low, "R9 stop held by stretched SCL", {en_flags[2], sda_low}, 3);
      check(stop_cnt == 0, "R9 no stop edge while stretched", stop_cnt, 0);
      stretch = 1'b0;
      wait_idle();
      check(stop_cnt == 1, "R3 stop edge seen", stop_cnt, 1);
      check(!scl_low && !sda_low && en_flags == 0, "R3 lines released", {scl_low, sda_low}, 0);

      // R8 divider zero acts as one
      half_div = 8'd0;
      issue(5'b00001);
      n = 0;
      while (en_flags[0]) begin @(negedge clk); n++; end
      check(n == 1, "R8 zero divider start duration", n, 1);
      issue(5'b00100);
      wait_idle();

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0 && rx_seen == 3, "R4 all bytes delivered", rx_seen, 3);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule